// File: doc/BRIEF.md
# In-Order Issue Scoreboard

This block is the interlock at the issue stage of a pipeline that dispatches instructions strictly in program order while its function units finish out of order. Each cycle it looks at the single decoded instruction waiting in the issue stage. That instruction carries a target function unit, a destination register with its own valid flag, and two source registers. The block decides in the same cycle whether the instruction may leave for its unit, or whether fetch and decode must hold.

The table behind that decision is deliberately small. Source operands are read at the moment of dispatch, so a later write can never overtake an earlier read, and no source columns are stored. What remains is a write-pending bit per architectural register, held inside the block, and a busy bit per function unit, taken live from the units themselves. A dispatch that writes a register sets that register's pending bit. A write-back clears it. A clear arriving on the same edge is already visible to the hazard check.

Top module: `issue_scoreboard`

## Requirements
- R1: After reset every register's write-pending bit is zero, so an instruction naming any register as source or destination dispatches when its unit is free.
- R2: An instruction whose target unit index (0 = integer, 1 = add, 2 = multiply, 3 = divide) has its `unit_busy` bit set is held.
- R3: An instruction is held when either source register has a pending write that is not being written back in the same cycle.
- R4: With `in_dst_valid` high, an instruction is held when its destination already has a pending write that is not being written back in the same cycle.
- R5: A dispatch with `in_dst_valid` high marks its destination pending from the next cycle onward, so later readers or writers of that register are held.
- R6: A write-back clears that register's pending bit. A write-back in the same cycle as the hazard check already counts as cleared.
- R7: With `in_dst_valid` low, the destination field is ignored. It takes part in no hazard check and marks no register pending.
- R8: `stall` is high exactly when `in_valid` is high and `dispatch` is low. With `in_valid` low, both outputs are low.
- R9: When a dispatch targets a register that is being written back in the same cycle, the new pending mark wins and the register stays pending afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue stage holds an instruction |
| in_unit | input | UNIT_W (2) | Target function unit index |
| in_dst | input | REG_W (5) | Destination register |
| in_dst_valid | input | 1 | Instruction writes a destination |
| in_src1 | input | REG_W (5) | First source register |
| in_src2 | input | REG_W (5) | Second source register |
| unit_busy | input | NUM_UNITS (4) | Per-unit busy flags from the function units |
| wb_valid | input | NUM_WB (1) | Write-back port valid flags |
| wb_reg | input | NUM_WB*REG_W (5) | Write-back register indices, port 0 in the low bits |
| dispatch | output | 1 | Instruction leaves the issue stage this cycle |
| stall | output | 1 | Fetch and decode must hold |

## Verification
The embedded properties assume that every input is known once reset has been released. They also assume that a write-back names a register only after the dispatch that marked it pending. The bench keeps to both rules: its random phase picks write-back registers only from the set that its own model currently holds as pending. The bench drives the busy vector freely, because that vector is treated purely as an input.

// File: rtl/sb_pkg.sv
package sb_pkg;

   typedef enum logic [1:0] {
      FU_INT = 2'd0,
      FU_ADD = 2'd1,
      FU_MUL = 2'd2,
      FU_DIV = 2'd3
   } fu_class_e;

   typedef struct packed {
      logic unit_busy;
      logic raw;
      logic waw;
   } hazard_t;

   localparam int DEF_NUM_REGS  = 32;
   localparam int DEF_NUM_UNITS = 4;
   localparam int DEF_NUM_WB    = 1;

endpackage

// File: rtl/sb_clear_mask.sv
module sb_clear_mask #(
   parameter int NUM_REGS = 32,
   parameter int NUM_WB   = 1,
   localparam int REG_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_WB-1:0]       wb_valid,
   input  logic [NUM_WB*REG_W-1:0] wb_reg,
   output logic [NUM_REGS-1:0]     clr_mask
);

   logic [NUM_WB-1:0][NUM_REGS-1:0] port_mask;

   for (genvar p = 0; p < NUM_WB; p++) begin : g_port
      logic [REG_W-1:0] idx;
      assign idx = wb_reg[p*REG_W +: REG_W];
      always_comb begin
         port_mask[p] = '0;
         if (wb_valid[p]) port_mask[p][idx] = 1'b1;
      end
   end

   always_comb begin
      clr_mask = '0;
      for (int p = 0; p < NUM_WB; p++) clr_mask = clr_mask | port_mask[p];
   end

endmodule

// File: rtl/sb_pend_vec.sv
module sb_pend_vec #(
   parameter int NUM_REGS = 32,
   localparam int REG_W   = $clog2(NUM_REGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_REGS-1:0] clr_mask,
   input  logic                set_en,
   input  logic [REG_W-1:0]    set_idx,
   output logic [NUM_REGS-1:0] pend_q,
   output logic [NUM_REGS-1:0] pend_eff
);

   logic [NUM_REGS-1:0] set_mask;

   assign pend_eff = pend_q & ~clr_mask;

   always_comb begin
      set_mask = '0;
      if (set_en) set_mask[set_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_eff | set_mask;
   end

   // R5
   pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_en |=> pend_q[$past(set_idx)]);

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
      // R6
      pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_mask[r] && !(set_en && set_idx == REG_W'(r))) |=> !pend_q[r]);
   end

endmodule

// File: rtl/sb_hazard_check.sv
module sb_hazard_check
   import sb_pkg::*;
#(
   parameter int NUM_REGS  = 32,
   parameter int NUM_UNITS = 4,
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic [NUM_REGS-1:0]  pend_eff,
   input  logic [NUM_UNITS-1:0] unit_busy,
   input  logic [UNIT_W-1:0]    in_unit,
   input  logic [REG_W-1:0]     in_dst,
   input  logic                 in_dst_valid,
   input  logic [REG_W-1:0]     in_src1,
   input  logic [REG_W-1:0]     in_src2,
   output hazard_t              hz
);

   localparam bit UNITS_POW2 = (NUM_UNITS == (1 << UNIT_W));

   logic unit_held;

   if (UNITS_POW2) begin : g_unit_direct
      assign unit_held = unit_busy[in_unit];
   end else begin : g_unit_guarded
      logic [NUM_UNITS:0] busy_ext;
      assign busy_ext  = {1'b1, unit_busy};
      assign unit_held = ({1'b0, in_unit} >= (UNIT_W+1)'(NUM_UNITS)) ? busy_ext[NUM_UNITS]
                                                                     : unit_busy[in_unit];
   end

   assign hz.unit_busy = unit_held;
   assign hz.raw       = pend_eff[in_src1] | pend_eff[in_src2];
   assign hz.waw       = in_dst_valid & pend_eff[in_dst];

endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
   import sb_pkg::*;
#(
   parameter int NUM_REGS  = DEF_NUM_REGS,
   parameter int NUM_UNITS = DEF_NUM_UNITS,
   parameter int NUM_WB    = DEF_NUM_WB,
   localparam int REG_W    = $clog2(NUM_REGS),
   localparam int UNIT_W   = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [UNIT_W-1:0]       in_unit,
   input  logic [REG_W-1:0]        in_dst,
   input  logic                    in_dst_valid,
   input  logic [REG_W-1:0]        in_src1,
   input  logic [REG_W-1:0]        in_src2,
   input  logic [NUM_UNITS-1:0]    unit_busy,
   input  logic [NUM_WB-1:0]       wb_valid,
   input  logic [NUM_WB*REG_W-1:0] wb_reg,
   output logic                    dispatch,
   output logic                    stall
);

   initial begin
      regs_pow2_chk: assert (NUM_REGS >= 2 && NUM_REGS == (1 << REG_W))
         else $fatal(1, "NUM_REGS must be a power of two of at least 2");
      units_chk: assert (NUM_UNITS >= 1)
         else $fatal(1, "NUM_UNITS must be at least 1");
      wb_chk: assert (NUM_WB >= 1)
         else $fatal(1, "NUM_WB must be at least 1");
   end

   logic [NUM_REGS-1:0] clr_mask;
   logic [NUM_REGS-1:0] pend_q;
   logic [NUM_REGS-1:0] pend_eff;
   hazard_t             hz;

   sb_clear_mask #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB)) u_clr (
      .wb_valid (wb_valid),
      .wb_reg   (wb_reg),
      .clr_mask (clr_mask)
   );

   sb_hazard_check #(.NUM_REGS(NUM_REGS), .NUM_UNITS(NUM_UNITS)) u_hz (
      .pend_eff     (pend_eff),
      .unit_busy    (unit_busy),
      .in_unit      (in_unit),
      .in_dst       (in_dst),
      .in_dst_valid (in_dst_valid),
      .in_src1      (in_src1),
      .in_src2      (in_src2),
      .hz           (hz)
   );

   assign dispatch = in_valid & ~(hz.unit_busy | hz.raw | hz.waw);
   assign stall    = in_valid & ~dispatch;

   sb_pend_vec #(.NUM_REGS(NUM_REGS)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_mask (clr_mask),
      .set_en   (dispatch & in_dst_valid),
      .set_idx  (in_dst),
      .pend_q   (pend_q),
      .pend_eff (pend_eff)
   );

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!dispatch && !stall));

   // R8
   one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (dispatch != stall));

   // R3
   raw_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch |-> (!pend_q[in_src1] || clr_mask[in_src1]));

   // R3
   raw_src2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch |-> (!pend_q[in_src2] || clr_mask[in_src2]));

   // R4
   waw_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dispatch && in_dst_valid) |-> (!pend_q[in_dst] || clr_mask[in_dst]));

   // R9
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dispatch && in_dst_valid && clr_mask[in_dst]) |=> pend_q[$past(in_dst)]);

   if (NUM_UNITS == (1 << UNIT_W)) begin : g_busy_chk
      // R2
      busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         dispatch |-> !unit_busy[in_unit]);
   end

endmodule

// File: tb/issue_scoreboard_tb.sv
module issue_scoreboard_tb;
   import sb_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [1:0] in_unit = '0;
   logic [4:0] in_dst = '0;
   logic       in_dst_valid = 1'b0;
   logic [4:0] in_src1 = '0;
   logic [4:0] in_src2 = '0;
   logic [3:0] unit_busy = '0;
   logic [0:0] wb_valid = '0;
   logic [4:0] wb_reg = '0;
   logic       dispatch, stall;

   int n_checks = 0;
   int n_fail = 0;
   bit model_pend [32];
   bit done = 1'b0;

   always #5 clk = ~clk;

   issue_scoreboard u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_unit(in_unit),
      .in_dst(in_dst), .in_dst_valid(in_dst_valid), .in_src1(in_src1),
      .in_src2(in_src2), .unit_busy(unit_busy), .wb_valid(wb_valid),
      .wb_reg(wb_reg), .dispatch(dispatch), .stall(stall)
   );

   task automatic step(input bit v, input int unit, input int dst, input bit dv,
                       input int s1, input int s2, input logic [3:0] busy,
                       input bit wbv, input int wbr, input string tag);
      bit pend_now [32];
      bit exp_disp, exp_stall;
      in_valid = v; in_unit = unit[1:0]; in_dst = dst[4:0]; in_dst_valid = dv;
      in_src1 = s1[4:0]; in_src2 = s2[4:0]; unit_busy = busy;
      wb_valid = wbv; wb_reg = wbr[4:0];
      #1;
      pend_now = model_pend;
      if (wbv) pend_now[wbr] = 1'b0;
      exp_disp = v && !busy[unit] && !pend_now[s1] && !pend_now[s2] && !(dv && pend_now[dst]);
      exp_stall = v && !exp_disp;
      n_checks++;
      if (dispatch !== exp_disp || stall !== exp_stall) begin
         n_fail++;
         $display("FAIL %s: dispatch/stall actual %b%b expected %b%b", tag,
                  dispatch, stall, exp_disp, exp_stall);
      end
      @(posedge clk);
      model_pend = pend_now;
      if (exp_disp && dv) model_pend[dst] = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      #1_500_000;
      if (!done) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      foreach (model_pend[i]) model_pend[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: every register free after reset
      for (int r = 0; r < 32; r++) step(1, FU_INT, r, 0, r, r, 4'b0, 0, 0, "R1");
      // R8: idle issue stage
      step(0, FU_INT, 0, 1, 0, 0, 4'b1111, 0, 0, "R8");
      // R2: busy unit holds, a free unit does not
      step(1, FU_MUL, 3, 0, 1, 2, 4'b0100, 0, 0, "R2");
      step(1, FU_ADD, 3, 0, 1, 2, 4'b0100, 0, 0, "R2");
      step(1, FU_DIV, 3, 0, 1, 2, 4'b1000, 0, 0, "R2");
      // R5 then R4: mark register 6, then a second writer is held
      step(1, FU_DIV, 6, 1, 6, 4, 4'b0, 0, 0, "R5");
      step(1, FU_ADD, 6, 1, 1, 2, 4'b0, 0, 0, "R4");
      // R7: no destination, register 6 field ignored
      step(1, FU_ADD, 6, 0, 1, 2, 4'b0, 0, 0, "R7");
      // R3: reads of 6 held on either source
      step(1, FU_ADD, 7, 1, 6, 2, 4'b0, 0, 0, "R3");
      step(1, FU_ADD, 7, 1, 2, 6, 4'b0, 0, 0, "R3");
      // R6: same-cycle write-back bypass, then cleared state
      step(1, FU_ADD, 7, 1, 6, 2, 4'b0, 1, 6, "R6");
      step(1, FU_INT, 8, 0, 6, 6, 4'b0, 0, 0, "R6");
      step(1, FU_INT, 6, 1, 0, 0, 4'b0, 1, 7, "R6");
      // R9: re-dispatch to 9 while 9 is written back, 9 stays pending
      step(1, FU_MUL, 9, 1, 1, 1, 4'b0, 0, 0, "R5");
      step(1, FU_MUL, 9, 1, 1, 1, 4'b0, 1, 9, "R9");
      step(1, FU_INT, 10, 0, 9, 1, 4'b0, 0, 0, "R9");
      // R7: destination 12 without valid leaves 12 free
      step(1, FU_INT, 12, 0, 1, 1, 4'b0, 0, 0, "R7");
      step(1, FU_INT, 13, 0, 12, 12, 4'b0, 0, 0, "R7");
      // Random traffic against the model
      for (int k = 0; k < 3000; k++) begin
         int start, wr;
         bit wv;
         wv = 1'b0; wr = 0;
         if ($urandom_range(1, 0) == 1) begin
            start = int'($urandom_range(31, 0));
            for (int j = 0; j < 32; j++)
               if (!wv && model_pend[(start + j) % 32]) begin
                  wv = 1'b1; wr = (start + j) % 32;
               end
         end
         step($urandom_range(3, 0) != 0, int'($urandom_range(3, 0)),
              int'($urandom_range(31, 0)), $urandom_range(3, 0) != 0,
              int'($urandom_range(31, 0)), int'($urandom_range(31, 0)),
              4'($urandom_range(15, 0) & $urandom_range(15, 0)), wv, wr,
              "R2/R3/R4/R6/R8");
      end
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule